// File: doc/BRIEF.md
# Serial EEPROM Command Engine

This block is the instruction engine on the slave side of a serial EEPROM. An SPI front end delivers whole received bytes and tells it when chip select falls and rises. The engine decodes the opcode at the start of each transaction and runs the matching sequence. It can set or clear the write-enable latch, return the status byte, program the status byte, stream data out of the byte array, or gather a page of data for programming. Bit shifting, pause handling and the protection decision live in neighbouring blocks. For protection, this engine shows the address it is about to program and receives one write-allowed flag back.

A page write is committed by a self-timed cycle. While the cycle runs the engine reports busy, and it walks the page buffer one offset per clock. Each buffered byte whose address the protection block allows is written to the array. A countdown of `TWC_CYCLES` clocks follows the walk. When the cycle ends, the write-enable latch clears. The array holds 2^`ADDR_W` bytes. Product sizes use 14 or 15, and any higher address bits are don't-care.

Top module: `seeprom_cmd_engine`

## Requirements
- R1: The opcode byte is decoded only when its upper nibble is zero, and bit 3 is ignored. On bits 2:0, 110 sets the write-enable latch, 100 clears it, 101 selects the status read, 001 the status write, 011 the array read and 010 the array write.
- R2: Any other opcode (nonzero upper nibble, or 000 or 111 in bits 2:0) causes every following byte to be ignored. `tx_oe` then stays low until the next `cs_fall`.
- R3: An array read takes a high address byte and then a low one. Address bits at and above `ADDR_W` are ignored. `tx_byte` shows the addressed byte, and each further received byte advances the address by one, wrapping from the top of the array to zero.
- R4: Data bytes of an array write go to the page buffer. Only the low 6 address bits advance, wrapping inside the 64-byte page, and a later byte replaces an earlier one at the same offset.
- R5: A write cycle starts only on `cs_rise` with the write-enable latch set and at least one complete byte received (a data byte for an array write). Otherwise the transaction is discarded, busy stays low and the latch keeps its value.
- R6: `busy` stays high for 64+`TWC_CYCLES` clocks after an array commit starts, or for `TWC_CYCLES` clocks after a status commit starts. The write-enable latch clears on the edge where busy falls.
- R7: While busy, every opcode except the status read is ignored. The status byte reads 0xFF during that time.
- R8: The status byte holds busy in bit 0, the latch in bit 1, the block-protect field in bits 3:2 and the lock-enable in bit 7; bits 6:4 read 0. A status write copies data bits 7 and 3:2 on `cs_rise`, but only when the latch is set and `sr_wr_allow` is high.
- R9: During a commit, a buffered byte is written only if `wr_allow` is high for the address on `prot_addr`. The other bytes of the same page are still written.
- R10: After reset, busy, `tx_oe`, the latch, the lock-enable and the block-protect field are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_fall | input | 1 | One-clock pulse: chip select went low |
| cs_rise | input | 1 | One-clock pulse: chip select went high |
| rx_valid | input | 1 | One-clock pulse: a complete byte was received |
| rx_byte | input | 8 | Received byte, MSB-first as assembled by the front end |
| tx_oe | output | 1 | Output drive enable; low means high impedance |
| tx_byte | output | 8 | Byte for the front end to shift out |
| busy | output | 1 | Self-timed write cycle in progress |
| sr_wpen | output | 1 | Stored lock-enable bit, for the protection block |
| sr_bp | output | 2 | Stored block-protect field, for the protection block |
| sr_wr_allow | input | 1 | Protection block permits a status write |
| prot_addr | output | ADDR_W | Array address being committed |
| wr_allow | input | 1 | Protection block permits writing `prot_addr` |

## Verification
The self-timed cycle ending and a new opcode arriving can fall in the same clock. The bench provokes this by polling status and sending opcodes without pause while the countdown expires. An opcode is judged by the busy value held in the clock it arrives, so a latch-set request that lands on the final busy clock is dropped and the latch still clears at that edge. The behavioural model applies the same rule on its own and is compared with `busy`, `tx_oe` and `tx_byte` every clock. A page commit that walks into protected offsets is also compared byte by byte.

// File: rtl/seeprom_pkg.sv
package seeprom_pkg;
  typedef enum logic [3:0] {
    ST_IGN, ST_OP, ST_AHI, ST_ALO, ST_RD, ST_WR, ST_SR, ST_SRW, ST_SRD
  } cmd_st_t;

  typedef enum logic [1:0] {PH_IDLE, PH_COMMIT, PH_WAIT} wr_ph_t;

  localparam logic [2:0] OP_WEL_SET = 3'b110;
  localparam logic [2:0] OP_WEL_CLR = 3'b100;
  localparam logic [2:0] OP_SR_RD   = 3'b101;
  localparam logic [2:0] OP_SR_WR   = 3'b001;
  localparam logic [2:0] OP_ARR_RD  = 3'b011;
  localparam logic [2:0] OP_ARR_WR  = 3'b010;
endpackage

// File: rtl/seeprom_cmd_fsm.sv
module seeprom_cmd_fsm
  import seeprom_pkg::*;
#(
  parameter int AW  = 11,
  parameter int PAW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_fall,
  input  logic          cs_rise,
  input  logic          rx_valid,
  input  logic [7:0]    rx_byte,
  input  logic          busy,
  input  logic          cyc_done,
  input  logic          sr_wr_allow,
  output logic          tx_oe,
  output logic          sr_sel,
  output logic [AW-1:0] cur_addr,
  output logic          pb_wr,
  output logic          pb_clr,
  output logic          start_page,
  output logic          start_sr,
  output logic          wel,
  output logic          wpen,
  output logic [1:0]    bp
);
  cmd_st_t       st, st_n;
  logic          is_wr, is_wr_n;
  logic [7:0]    addr_hi, addr_hi_n;
  logic [AW-1:0] addr_n;
  logic          wel_n, wpen_n, got, got_n;
  logic [1:0]    bp_n;
  logic          nw_wpen, nw_wpen_n;
  logic [1:0]    nw_bp, nw_bp_n;
  logic          op_ok;

  assign op_ok = (rx_byte[7:4] == 4'h0) && (!busy || rx_byte[2:0] == OP_SR_RD);

  always_comb begin
    st_n = st; is_wr_n = is_wr; addr_hi_n = addr_hi; addr_n = cur_addr;
    wel_n = wel; wpen_n = wpen; bp_n = bp; got_n = got;
    nw_wpen_n = nw_wpen; nw_bp_n = nw_bp;
    pb_wr = 1'b0; pb_clr = 1'b0; start_page = 1'b0; start_sr = 1'b0;
    if (cs_fall) begin
      st_n  = ST_OP;
      got_n = 1'b0;
    end else if (cs_rise) begin
      st_n = ST_IGN;
      if (st == ST_WR && wel && got) start_page = 1'b1;
      if (st == ST_SRD && wel && sr_wr_allow) begin
        start_sr = 1'b1;
        wpen_n   = nw_wpen;
        bp_n     = nw_bp;
      end
    end else if (rx_valid) begin
      unique case (st)
        ST_OP: begin
          st_n = ST_IGN;
          if (op_ok) begin
            unique case (rx_byte[2:0])
              OP_WEL_SET: wel_n = 1'b1;
              OP_WEL_CLR: wel_n = 1'b0;
              OP_SR_RD:   st_n  = ST_SR;
              OP_SR_WR:   st_n  = ST_SRW;
              OP_ARR_RD:  begin st_n = ST_AHI; is_wr_n = 1'b0; end
              OP_ARR_WR:  begin st_n = ST_AHI; is_wr_n = 1'b1; pb_clr = 1'b1; end
              default:    st_n  = ST_IGN;
            endcase
          end
        end
        ST_AHI: begin addr_hi_n = rx_byte; st_n = ST_ALO; end
        ST_ALO: begin
          addr_n = AW'({addr_hi, rx_byte});
          st_n   = is_wr ? ST_WR : ST_RD;
        end
        ST_RD: addr_n = cur_addr + AW'(1);
        ST_WR: begin
          pb_wr = 1'b1;
          got_n = 1'b1;
          addr_n[PAW-1:0] = cur_addr[PAW-1:0] + PAW'(1);
        end
        ST_SRW: begin
          nw_wpen_n = rx_byte[7];
          nw_bp_n   = rx_byte[3:2];
          st_n      = ST_SRD;
        end
        default: st_n = st;
      endcase
    end
    if (cyc_done) wel_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IGN; is_wr <= 1'b0; addr_hi <= '0; cur_addr <= '0;
      wel <= 1'b0; wpen <= 1'b0; bp <= '0; got <= 1'b0;
      nw_wpen <= 1'b0; nw_bp <= '0;
    end else begin
      st <= st_n; is_wr <= is_wr_n; addr_hi <= addr_hi_n; cur_addr <= addr_n;
      wel <= wel_n; wpen <= wpen_n; bp <= bp_n; got <= got_n;
      nw_wpen <= nw_wpen_n; nw_bp <= nw_bp_n;
    end
  end

  assign tx_oe  = (st == ST_RD) || (st == ST_SR);
  assign sr_sel = (st == ST_SR);

  AST_BUSY_ONLY_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && st == ST_OP && rx_valid && !cs_fall && !cs_rise && rx_byte[2:0] != OP_SR_RD)
    |=> (st == ST_IGN)); // R7
  AST_PAGE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WR && rx_valid && !cs_fall && !cs_rise)
    |=> (cur_addr[AW-1:PAW] == $past(cur_addr[AW-1:PAW]))); // R4
  AST_IGN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IGN && !cs_fall) |=> !tx_oe); // R2
endmodule

// File: rtl/seeprom_page_buf.sv
module seeprom_page_buf #(
  parameter int PAW = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic           wr,
  input  logic [PAW-1:0] wr_off,
  input  logic [7:0]     wr_data,
  input  logic [PAW-1:0] rd_off,
  output logic [7:0]     rd_data,
  output logic           rd_valid
);
  localparam int NB = 1 << PAW;

  logic [7:0]    data_q [NB];
  logic [NB-1:0] vld_q, vld_n;

  always_comb begin
    vld_n = vld_q;
    if (clr) vld_n = '0;
    else if (wr) vld_n[wr_off] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_n;
  end

  always_ff @(posedge clk) begin
    if (wr) data_q[wr_off] <= wr_data;
  end

  assign rd_data  = data_q[rd_off];
  assign rd_valid = vld_q[rd_off];
endmodule

// File: rtl/seeprom_wr_timer.sv
module seeprom_wr_timer
  import seeprom_pkg::*;
#(
  parameter int PAW        = 6,
  parameter int TWC_CYCLES = 20
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_page,
  input  logic           start_sr,
  output logic           busy,
  output logic           commit_act,
  output logic [PAW-1:0] commit_off,
  output logic           done
);
  localparam int CW = $clog2(TWC_CYCLES + 1);

  wr_ph_t         ph, ph_n;
  logic [PAW-1:0] off_n;
  logic [CW-1:0]  cnt, cnt_n;

  assign done = (ph == PH_WAIT) && (cnt == CW'(TWC_CYCLES - 1));

  always_comb begin
    ph_n = ph; off_n = commit_off; cnt_n = cnt;
    unique case (ph)
      PH_IDLE: begin
        if (start_page) begin ph_n = PH_COMMIT; off_n = '0; end
        else if (start_sr) begin ph_n = PH_WAIT; cnt_n = '0; end
      end
      PH_COMMIT: begin
        off_n = commit_off + PAW'(1);
        if (&commit_off) begin ph_n = PH_WAIT; cnt_n = '0; end
      end
      PH_WAIT: begin
        cnt_n = cnt + CW'(1);
        if (done) ph_n = PH_IDLE;
      end
      default: ph_n = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= PH_IDLE; commit_off <= '0; cnt <= '0;
    end else begin
      ph <= ph_n; commit_off <= off_n; cnt <= cnt_n;
    end
  end

  assign busy       = (ph != PH_IDLE);
  assign commit_act = (ph == PH_COMMIT);

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy); // R6
endmodule

// File: rtl/seeprom_array.sv
module seeprom_array #(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  localparam int DEPTH = 1 << AW;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/seeprom_cmd_engine.sv
module seeprom_cmd_engine #(
  parameter int ADDR_W     = 11,
  parameter int PAGE_W     = 6,
  parameter int TWC_CYCLES = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_fall,
  input  logic              cs_rise,
  input  logic              rx_valid,
  input  logic [7:0]        rx_byte,
  output logic              tx_oe,
  output logic [7:0]        tx_byte,
  output logic              busy,
  output logic              sr_wpen,
  output logic [1:0]        sr_bp,
  input  logic              sr_wr_allow,
  output logic [ADDR_W-1:0] prot_addr,
  input  logic              wr_allow
);
  logic              sr_sel, pb_wr, pb_clr, start_page, start_sr, wel, cyc_done;
  logic              commit_act, pb_rd_valid, mem_we;
  logic [ADDR_W-1:0] cur_addr;
  logic [PAGE_W-1:0] commit_off;
  logic [7:0]        pb_rd_data, arr_rd_data, status;

  seeprom_cmd_fsm #(.AW(ADDR_W), .PAW(PAGE_W)) u_fsm (
    .clk, .rst_n, .cs_fall, .cs_rise, .rx_valid, .rx_byte,
    .busy, .cyc_done, .sr_wr_allow, .tx_oe, .sr_sel, .cur_addr,
    .pb_wr, .pb_clr, .start_page, .start_sr, .wel,
    .wpen(sr_wpen), .bp(sr_bp)
  );

  seeprom_page_buf #(.PAW(PAGE_W)) u_pbuf (
    .clk, .rst_n, .clr(pb_clr), .wr(pb_wr),
    .wr_off(cur_addr[PAGE_W-1:0]), .wr_data(rx_byte),
    .rd_off(commit_off), .rd_data(pb_rd_data), .rd_valid(pb_rd_valid)
  );

  seeprom_wr_timer #(.PAW(PAGE_W), .TWC_CYCLES(TWC_CYCLES)) u_timer (
    .clk, .rst_n, .start_page, .start_sr, .busy,
    .commit_act, .commit_off, .done(cyc_done)
  );

  assign prot_addr = {cur_addr[ADDR_W-1:PAGE_W], commit_off};
  assign mem_we    = commit_act && pb_rd_valid && wr_allow;

  seeprom_array #(.AW(ADDR_W)) u_array (
    .clk, .we(mem_we), .waddr(prot_addr), .wdata(pb_rd_data),
    .raddr(cur_addr), .rdata(arr_rd_data)
  );

  assign status  = busy ? 8'hFF : {sr_wpen, 3'b000, sr_bp, wel, 1'b0};
  assign tx_byte = sr_sel ? status : arr_rd_data;

  AST_START_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wel)); // R5
  AST_WEL_DROPS_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !wel); // R6
endmodule

// File: tb/tb_seeprom_cmd_engine.sv
module tb_seeprom_cmd_engine;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 11, PW = 6, TWC = 20;
  localparam int DEPTH = 1 << AW, PAGE = 1 << PW;
  localparam int M_IGN = 0, M_OP = 1, M_AH = 2, M_AL = 3, M_RD = 4,
                 M_WR = 5, M_SR = 6, M_SRW = 7, M_SRD = 8;

  logic clk = 1'b0, rst_n;
  logic cs_fall, cs_rise, rx_valid, sr_wr_allow, wr_allow;
  logic [7:0] rx_byte, tx_byte;
  logic tx_oe, busy, sr_wpen;
  logic [1:0] sr_bp;
  logic [AW-1:0] prot_addr;
  int prot_limit;
  int n_tests = 0, n_fail = 0;
  string cur_req = "R10";
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign wr_allow = (int'(prot_addr) < prot_limit);

  seeprom_cmd_engine #(.ADDR_W(AW), .PAGE_W(PW), .TWC_CYCLES(TWC)) dut (
    .clk, .rst_n, .cs_fall, .cs_rise, .rx_valid, .rx_byte, .tx_oe, .tx_byte,
    .busy, .sr_wpen, .sr_bp, .sr_wr_allow, .prot_addr, .wr_allow);

  // behavioural reference
  int m_st, m_addr, m_bcnt, m_base;
  logic [7:0] m_mem [DEPTH];
  logic [7:0] m_pb [PAGE];
  bit m_pv [PAGE];
  logic [7:0] m_hi, m_srn;
  bit m_isw, m_got, m_wel, m_wpen, m_bz;
  logic [1:0] m_bp;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = M_IGN; m_addr = 0; m_bcnt = 0; m_wel = 0; m_wpen = 0; m_bp = 0;
      m_got = 0; m_isw = 0;
      for (int i = 0; i < PAGE; i++) m_pv[i] = 0;
    end else begin
      m_bz = (m_bcnt > 0);
      if (m_bcnt > 0) begin
        m_bcnt--;
        if (m_bcnt == 0) m_wel = 0;
      end
      if (cs_fall) begin
        m_st = M_OP; m_got = 0;
      end else if (cs_rise) begin
        if (m_st == M_WR && m_wel && m_got) begin
          m_base = m_addr - (m_addr % PAGE);
          for (int i = 0; i < PAGE; i++)
            if (m_pv[i] && (m_base + i) < prot_limit) m_mem[m_base + i] = m_pb[i];
          m_bcnt = PAGE + TWC;
        end
        if (m_st == M_SRD && m_wel && sr_wr_allow) begin
          m_wpen = m_srn[7]; m_bp = m_srn[3:2]; m_bcnt = TWC;
        end
        m_st = M_IGN;
      end else if (rx_valid) begin
        case (m_st)
          M_OP: begin
            m_st = M_IGN;
            if (rx_byte[7:4] == 0 && (!m_bz || rx_byte[2:0] == 3'b101))
              case (rx_byte[2:0])
                3'b110: m_wel = 1;
                3'b100: m_wel = 0;
                3'b101: m_st = M_SR;
                3'b001: m_st = M_SRW;
                3'b011: begin m_st = M_AH; m_isw = 0; end
                3'b010: begin
                  m_st = M_AH; m_isw = 1;
                  for (int i = 0; i < PAGE; i++) m_pv[i] = 0;
                end
                default: m_st = M_IGN;
              endcase
          end
          M_AH: begin m_hi = rx_byte; m_st = M_AL; end
          M_AL: begin
            m_addr = ((int'(m_hi) << 8) | int'(rx_byte)) % DEPTH;
            m_st = m_isw ? M_WR : M_RD;
          end
          M_RD: m_addr = (m_addr + 1) % DEPTH;
          M_WR: begin
            m_pb[m_addr % PAGE] = rx_byte; m_pv[m_addr % PAGE] = 1; m_got = 1;
            m_addr = (m_addr - (m_addr % PAGE)) + ((m_addr + 1) % PAGE);
          end
          M_SRW: begin m_srn = rx_byte; m_st = M_SRD; end
          default: ;
        endcase
      end
    end
  end

  task automatic chk(string what, logic [7:0] act, logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n === 1'b1 && !finished) begin
      logic [7:0] etx;
      etx = (m_st == M_SR) ? ((m_bcnt > 0) ? 8'hFF : {m_wpen, 3'b000, m_bp, m_wel, 1'b0})
                           : m_mem[m_addr];
      chk("busy", {7'd0, busy}, {7'd0, m_bcnt > 0});
      chk("tx_oe", {7'd0, tx_oe}, {7'd0, (m_st == M_RD || m_st == M_SR)});
      chk("status fields", {5'd0, sr_wpen, sr_bp}, {5'd0, m_wpen, m_bp});
      if (tx_oe === 1'b1) chk("tx_byte", tx_byte, etx);
    end
  end

  task automatic start_cs; cs_fall = 1; @(negedge clk); cs_fall = 0; endtask
  task automatic send(input logic [7:0] b);
    rx_byte = b; rx_valid = 1; @(negedge clk); rx_valid = 0; @(negedge clk);
  endtask
  task automatic end_cs; cs_rise = 1; @(negedge clk); cs_rise = 0; @(negedge clk); endtask
  task automatic cmd1(input logic [7:0] op); start_cs(); send(op); end_cs(); endtask
  task automatic read_status(input int n);
    start_cs(); send(8'h05); for (int i = 0; i < n; i++) send(8'h00); end_cs();
  endtask
  task automatic read_arr(input logic [7:0] hi, input logic [7:0] lo, input int n);
    start_cs(); send(8'h03); send(hi); send(lo);
    for (int i = 0; i < n; i++) send(8'h00);
    end_cs();
  endtask
  task automatic wait_idle; repeat (PAGE + TWC + 4) @(negedge clk); endtask

  initial begin
    cs_fall = 0; cs_rise = 0; rx_valid = 0; rx_byte = 0; sr_wr_allow = 1;
    prot_limit = DEPTH; rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    cur_req = "R10"; repeat (4) @(negedge clk);
    cur_req = "R8";  read_status(2);
    cur_req = "R1";  cmd1(8'h06); read_status(1); cmd1(8'h04); read_status(1);
    cmd1(8'h0E); read_status(1); cmd1(8'h0C); read_status(1);
    cur_req = "R2";  start_cs(); send(8'h16); send(8'h03); send(8'h00); end_cs();
    start_cs(); send(8'h07); send(8'h00); end_cs(); read_status(1);
    cur_req = "R4";  cmd1(8'h06);
    start_cs(); send(8'h02); send(8'h01); send(8'h03);
    for (int i = 0; i < 66; i++) send(8'h40 + 8'(i));
    end_cs();
    cur_req = "R7";  read_status(3); cmd1(8'h06);
    read_arr(8'h01, 8'h00, 2);
    cur_req = "R6";  start_cs(); send(8'h05);
    for (int i = 0; i < 40; i++) send(8'h00);
    end_cs(); read_status(1);
    cur_req = "R3";  read_arr(8'h01, 8'h00, 64); read_arr(8'hF9, 8'h05, 3);
    cur_req = "R4";  cmd1(8'h06); start_cs(); send(8'h02); send(8'h00); send(8'h00);
    send(8'hA1); send(8'hA2); end_cs(); wait_idle();
    cmd1(8'h06); start_cs(); send(8'h02); send(8'h07); send(8'hFE);
    send(8'hB1); send(8'hB2); end_cs(); wait_idle();
    cur_req = "R3";  read_arr(8'h07, 8'hFE, 4);
    cur_req = "R9";  prot_limit = 'h110;
    cmd1(8'h06); start_cs(); send(8'h02); send(8'h01); send(8'h0C);
    for (int i = 0; i < 8; i++) send(8'hC0 + 8'(i));
    end_cs(); wait_idle(); prot_limit = DEPTH; read_arr(8'h01, 8'h0A, 10);
    cur_req = "R5";  cmd1(8'h04); start_cs(); send(8'h02); send(8'h01); send(8'h00);
    send(8'h55); end_cs(); read_status(1); read_arr(8'h01, 8'h00, 2);
    cmd1(8'h06); start_cs(); send(8'h02); send(8'h01); send(8'h00); end_cs();
    read_status(1);
    cur_req = "R8";  start_cs(); send(8'h01); send(8'h8C); end_cs(); read_status(2);
    wait_idle(); read_status(1);
    sr_wr_allow = 0; cmd1(8'h06); start_cs(); send(8'h01); send(8'h00); end_cs();
    read_status(1); sr_wr_allow = 1;
    cur_req = "R6";  start_cs(); send(8'h01); send(8'h04); end_cs();
    start_cs(); send(8'h05);
    for (int i = 0; i < TWC; i++) send(8'h00);
    end_cs(); read_status(1);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL %s watchdog: actual=timeout expected=completion", cur_req);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule